// File: doc/BRIEF.md
# Piecewise-Linear Channel Gain Corrector

The block takes one amplitude sample from each of four receiver channels and maps it back onto one common ideal response. Each channel has its own table of measured response points. Every entry pairs the amplitude the channel produced with the reference-source level that produced it, and carries a precomputed fixed-point slope toward the next entry. Correcting through each channel's own inverse curve removes the gain mismatch between the channels and the nonlinearity inside each one in the same pass. The four channels run side by side and share one stream handshake.

Each sample goes through two pipeline stages. The first stage compares the sample against all of the channel's stored breakpoints in parallel. A priority encoder turns that comparison into a segment index. The second stage computes `f_n + slope*(x - x_n)`, with the slope in fixed point, and clamps the result to the output range. The input stream and the output stream both use valid/ready. An input beat is taken on any edge where `in_valid` and `in_ready` are both high. An output beat is delivered on any edge where `out_valid` and `out_ready` are both high. When the consumer holds `out_ready` low while an output is waiting, the whole pipeline stalls and `in_ready` drops. No sample is lost or duplicated. The breakpoint tables are loaded through a plain write port while the stream is idle.

Top module: `pwl_gain_corrector`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1. Every channel table holds the identity curve: point i has x = f = i*2^DW/NPTS and a slope of 1.0, which is 1<<FRAC. A sample therefore comes out unchanged.
- R2: A sample x with x_i <= x < x_(i+1) uses segment i. The result is f_i + ((slope_i * (x - x_i)) >>> FRAC). The shift is arithmetic and rounds toward minus infinity. The slope field stored at index i belongs to segment i.
- R3: Each channel uses only its own table. A write with `tbl_we`=1 stores `tbl_x`, `tbl_f` and `tbl_slope` at index `tbl_idx` of channel `tbl_ch` on the clock edge, and no other channel's entry changes.
- R4: A sample below point 0 is extrapolated along segment 0. A sample at or above the last point is extrapolated along the last segment, NPTS-2.
- R5: A result below 0 comes out as 0, and a result above 2^DW-1 comes out as 2^DW-1.
- R6: With `out_ready` held at 1, a beat taken on edge E appears with `out_valid`=1 after edge E+1. `out_valid` is 0 after edge E when the previous edge took no beat.
- R7: While `out_valid`=1 and `out_ready`=0, `out_amp` and `out_valid` hold and `in_ready` is 0. Beats are delivered in the order they were taken, each exactly once.
- R8: A table write affects every sample taken on a later edge.
- R9: A sample equal to an interior control point x_i returns f_i exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Block can take a beat |
| in_amp | input | NCH*DW | Channel c amplitude at bits [c*DW +: DW], unsigned |
| out_valid | output | 1 | Corrected beat valid |
| out_ready | input | 1 | Consumer takes the beat |
| out_amp | output | NCH*DW | Corrected amplitudes, same packing as `in_amp` |
| tbl_we | input | 1 | Table write strobe |
| tbl_ch | input | $clog2(NCH) | Channel to write |
| tbl_idx | input | $clog2(NPTS) | Point index to write |
| tbl_x | input | DW | Measured amplitude of the point |
| tbl_f | input | DW | Reference level of the point |
| tbl_slope | input | SLW | Signed slope of segment idx, FRAC fractional bits |

## Verification
The bench programs four different curves: an identity curve, a gain of two, an uneven seven-segment curve and an offset curve. It then drives samples that sit exactly on breakpoints, one count below a breakpoint, below the first point and above the last. A search that treats the segment bounds with the wrong inclusive or exclusive edge shows up as a wrong result one count below x_1 on the offset channel and at the exact-point samples. Wrong clamping of the end segments or missing saturation makes the result wrap instead of pinning at 0 or 65535. A stall test holds `out_ready` low across three beats. A pipeline that keeps accepting would drop the middle beat or change `out_amp` while the output is held.

// File: rtl/pwl_pkg.sv
package pwl_pkg;
  localparam int PWL_NCH  = 4;
  localparam int PWL_DW   = 16;
  localparam int PWL_NPTS = 8;
  localparam int PWL_SLW  = 18;
  localparam int PWL_FRAC = 12;
endpackage

// File: rtl/pwl_cal_table.sv
module pwl_cal_table #(
  parameter int DW   = 16,
  parameter int NPTS = 8,
  parameter int SLW  = 18,
  parameter int FRAC = 12,
  localparam int IW  = $clog2(NPTS),
  localparam int SH  = DW - IW
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [IW-1:0]            wr_idx,
  input  logic [DW-1:0]            wr_x,
  input  logic [DW-1:0]            wr_f,
  input  logic [SLW-1:0]           wr_slope,
  output logic [NPTS-1:0][DW-1:0]  pts_x,
  input  logic [IW-1:0]            rd_seg,
  output logic [DW-1:0]            rd_x,
  output logic [DW-1:0]            rd_f,
  output logic [SLW-1:0]           rd_slope
);
  logic [NPTS-1:0][DW-1:0]  x_q;
  logic [NPTS-1:0][DW-1:0]  f_q;
  logic [NPTS-1:0][SLW-1:0] s_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NPTS; i++) begin
        x_q[i] <= DW'(i) << SH;
        f_q[i] <= DW'(i) << SH;
        s_q[i] <= SLW'(1) << FRAC;
      end
    end else if (wr_en) begin
      x_q[wr_idx] <= wr_x;
      f_q[wr_idx] <= wr_f;
      s_q[wr_idx] <= wr_slope;
    end
  end

  assign pts_x    = x_q;
  assign rd_x     = x_q[rd_seg];
  assign rd_f     = f_q[rd_seg];
  assign rd_slope = s_q[rd_seg];

  // R3: a write lands in the addressed entry on the next edge
  assert_write_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (x_q[$past(wr_idx)] == $past(wr_x)) && (f_q[$past(wr_idx)] == $past(wr_f))
              && (s_q[$past(wr_idx)] == $past(wr_slope)));
endmodule

// File: rtl/pwl_seg_search.sv
module pwl_seg_search #(
  parameter int DW   = 16,
  parameter int NPTS = 8,
  localparam int IW  = $clog2(NPTS),
  localparam int NSEG = NPTS - 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    chk_en,
  input  logic [DW-1:0]           x,
  input  logic [NPTS-1:0][DW-1:0] pts_x,
  output logic [IW-1:0]           seg
);
  logic [NSEG-1:0] ge;
  logic [NSEG-1:0] grant;

  assign ge[0] = 1'b1;
  for (genvar i = 1; i < NSEG; i++) begin : g_cmp
    assign ge[i] = (x >= pts_x[i]);
  end

  for (genvar i = 0; i < NSEG; i++) begin : g_pri
    if (i == NSEG - 1) begin : g_top
      assign grant[i] = ge[i];
    end else begin : g_mid
      assign grant[i] = ge[i] & ~ge[i+1];
    end
  end

  always_comb begin
    seg = '0;
    for (int i = 0; i < NSEG; i++) begin
      if (grant[i]) seg = seg | IW'(i);
    end
  end

  // R2: with ordered breakpoints exactly one segment claims the sample
  assert_single_segment_R2: assert property (@(posedge clk) disable iff (!rst_n)
    chk_en |-> $onehot(grant));
  // R4: the encoder never names a segment past the last one
  assert_seg_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    chk_en |-> (int'(seg) <= NSEG - 1));
endmodule

// File: rtl/pwl_interp.sv
module pwl_interp #(
  parameter int DW   = 16,
  parameter int SLW  = 18,
  parameter int FRAC = 12,
  localparam int MW  = SLW + DW + 1,
  localparam int PW  = MW + 1
) (
  input  logic [DW-1:0]  x,
  input  logic [DW-1:0]  xn,
  input  logic [DW-1:0]  fn,
  input  logic [SLW-1:0] slope,
  output logic [DW-1:0]  y
);
  logic signed [DW:0]    diff;
  logic signed [MW-1:0]  prod;
  logic signed [MW-1:0]  step;
  logic signed [PW-1:0]  acc;
  logic signed [PW-1:0]  top_val;

  assign diff    = $signed({1'b0, x}) - $signed({1'b0, xn});
  assign prod    = $signed(slope) * diff;
  assign step    = prod >>> FRAC;
  assign acc     = $signed({step[MW-1], step}) + $signed({{(PW-DW){1'b0}}, fn});
  assign top_val = $signed({{(PW-DW){1'b0}}, {DW{1'b1}}});

  always_comb begin
    if (acc < 0)            y = '0;
    else if (acc > top_val) y = {DW{1'b1}};
    else                    y = acc[DW-1:0];
  end
endmodule

// File: rtl/pwl_gain_corrector.sv
module pwl_gain_corrector
  import pwl_pkg::*;
#(
  parameter int NCH  = PWL_NCH,
  parameter int DW   = PWL_DW,
  parameter int NPTS = PWL_NPTS,
  parameter int SLW  = PWL_SLW,
  parameter int FRAC = PWL_FRAC,
  localparam int IW  = $clog2(NPTS),
  localparam int CW  = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [NCH*DW-1:0] in_amp,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [NCH*DW-1:0] out_amp,
  input  logic              tbl_we,
  input  logic [CW-1:0]     tbl_ch,
  input  logic [IW-1:0]     tbl_idx,
  input  logic [DW-1:0]     tbl_x,
  input  logic [DW-1:0]     tbl_f,
  input  logic [SLW-1:0]    tbl_slope
);
  logic adv;
  logic s1_vld;
  logic out_vld;

  assign adv       = !out_vld || out_ready;
  assign in_ready  = adv;
  assign out_valid = out_vld;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_vld  <= 1'b0;
      out_vld <= 1'b0;
    end else if (adv) begin
      s1_vld  <= in_valid;
      out_vld <= s1_vld;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [NPTS-1:0][DW-1:0] pts_x;
    logic [IW-1:0]           seg_d, seg_q;
    logic [DW-1:0]           x_q;
    logic [DW-1:0]           rx, rf, y;
    logic [SLW-1:0]          rs;

    pwl_cal_table #(.DW(DW), .NPTS(NPTS), .SLW(SLW), .FRAC(FRAC)) i_tbl (
      .clk(clk), .rst_n(rst_n),
      .wr_en(tbl_we && (tbl_ch == CW'(c))), .wr_idx(tbl_idx),
      .wr_x(tbl_x), .wr_f(tbl_f), .wr_slope(tbl_slope),
      .pts_x(pts_x), .rd_seg(seg_q), .rd_x(rx), .rd_f(rf), .rd_slope(rs)
    );

    pwl_seg_search #(.DW(DW), .NPTS(NPTS)) i_srch (
      .clk(clk), .rst_n(rst_n), .chk_en(in_valid && adv),
      .x(in_amp[c*DW +: DW]), .pts_x(pts_x), .seg(seg_d)
    );

    pwl_interp #(.DW(DW), .SLW(SLW), .FRAC(FRAC)) i_interp (
      .x(x_q), .xn(rx), .fn(rf), .slope(rs), .y(y)
    );

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        x_q                <= '0;
        seg_q              <= '0;
        out_amp[c*DW +: DW] <= '0;
      end else if (adv) begin
        x_q                <= in_amp[c*DW +: DW];
        seg_q              <= seg_d;
        out_amp[c*DW +: DW] <= y;
      end
    end
  end

  // R7: a stalled output beat holds its data and its valid
  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld && !out_ready |=> out_vld && $stable(out_amp));
  // R6: an accepted beat occupies the first stage next cycle
  assert_accept_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> s1_vld);
  // R6: a first-stage beat moves to the output when the pipe advances
  assert_stage_advance_R6: assert property (@(posedge clk) disable iff (!rst_n)
    s1_vld && in_ready |=> out_vld);
endmodule

// File: tb/test_pwl_gain_corrector.sv
module test_pwl_gain_corrector;
  localparam int NCH = 4, DW = 16, NPTS = 8, SLW = 18;

  logic clk = 0;
  logic rst_n = 0;
  logic in_valid = 0, out_ready = 1, tbl_we = 0;
  logic in_ready, out_valid;
  logic [NCH*DW-1:0] in_amp = '0;
  logic [NCH*DW-1:0] out_amp;
  logic [1:0] tbl_ch = '0;
  logic [2:0] tbl_idx = '0;
  logic [DW-1:0] tbl_x = '0, tbl_f = '0;
  logic [SLW-1:0] tbl_slope = '0;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pwl_gain_corrector i_pwl_gain_corrector (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_amp(in_amp),
    .out_valid(out_valid), .out_ready(out_ready), .out_amp(out_amp),
    .tbl_we(tbl_we), .tbl_ch(tbl_ch), .tbl_idx(tbl_idx), .tbl_x(tbl_x), .tbl_f(tbl_f),
    .tbl_slope(tbl_slope)
  );

  // {s0,s1,s2,s3, e0,e1,e2,e3}
  localparam logic [127:0] VEC [0:8] = '{
    {16'd0,     16'd0,     16'd0,     16'd0,     16'd0,     16'd0,     16'd0,     16'd0},
    {16'd8192,  16'd4096,  16'd1000,  16'd2000,  16'd8192,  16'd8192,  16'd2000,  16'd0},
    {16'd12345, 16'd10000, 16'd2500,  16'd10191, 16'd12345, 16'd20000, 16'd4250,  16'd8191},
    {16'd65535, 16'd20000, 16'd8000,  16'd65535, 16'd65535, 16'd40000, 16'd11500, 16'd63535},
    {16'd100,   16'd40000, 16'd50000, 16'd1999,  16'd100,   16'd65535, 16'd56498, 16'd0},
    {16'd0,     16'd32767, 16'd65535, 16'd2001,  16'd0,     16'd65534, 16'd65535, 16'd1},
    {16'd30000, 16'd16384, 16'd15000, 16'd30000, 16'd30000, 16'd32768, 16'd19999, 16'd28000},
    {16'd40000, 16'd1,     16'd30000, 16'd40000, 16'd40000, 16'd2,     16'd36998, 16'd38000},
    {16'd57344, 16'd28672, 16'd6000,  16'd59344, 16'd57344, 16'd57344, 16'd9000,  16'd57344}
  };

  localparam int C2X [0:7] = '{0, 1000, 3000, 6000, 10000, 20000, 40000, 60000};
  localparam int C2F [0:7] = '{0, 2000, 5000, 9000, 14000, 26000, 48000, 65000};
  localparam int C2S [0:7] = '{8192, 6144, 5461, 5120, 4915, 4505, 3481, 0};

  function automatic string vtag(int k);
    case (k)
      0, 4: return "R5";
      1, 8: return "R9";
      2, 3: return "R2";
      5:    return "R4";
      default: return "R3";
    endcase
  endfunction

  task automatic check(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(int ch, int idx, int x, int f, int s);
    @(negedge clk);
    tbl_we = 1; tbl_ch = 2'(ch); tbl_idx = 3'(idx);
    tbl_x = DW'(x); tbl_f = DW'(f); tbl_slope = SLW'(s);
    @(negedge clk);
    tbl_we = 0;
  endtask

  function automatic logic [NCH*DW-1:0] pack4(int a, int b, int c, int d);
    return {DW'(d), DW'(c), DW'(b), DW'(a)};
  endfunction

  // one beat with out_ready high; checks the R6 latency and returns the output
  task automatic beat(logic [NCH*DW-1:0] smp, output logic [NCH*DW-1:0] res);
    @(negedge clk);
    in_valid = 1; in_amp = smp;
    @(negedge clk);
    in_valid = 0;
    check("R6 not yet valid", int'(out_valid), 0);
    @(negedge clk);
    check("R6 valid after two edges", int'(out_valid), 1);
    res = out_amp;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL R6: watchdog expired, actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [NCH*DW-1:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 out_valid after reset", int'(out_valid), 0);
    check("R1 in_ready after reset", int'(in_ready), 1);
    beat(pack4(777, 43210, 5, 65535), r);
    check("R1 identity ch1", int'(r[16 +: 16]), 43210);
    check("R1 identity ch3", int'(r[48 +: 16]), 65535);

    for (int i = 0; i < NPTS; i++) begin
      wr(1, i, 4096*i, 8192*i, 8192);
      wr(2, i, C2X[i], C2F[i], C2S[i]);
      wr(3, i, 8192*i + 2000, 8192*i, 4096);
    end

    for (int k = 0; k < 9; k++) begin
      beat({VEC[k][79:64], VEC[k][95:80], VEC[k][111:96], VEC[k][127:112]}, r);
      check("R1 ch0", int'(r[0 +: 16]), int'(VEC[k][63:48]));
      check({vtag(k), " ch1"}, int'(r[16 +: 16]), int'(VEC[k][47:32]));
      check({vtag(k), " ch2"}, int'(r[32 +: 16]), int'(VEC[k][31:16]));
      check({vtag(k), " ch3"}, int'(r[48 +: 16]), int'(VEC[k][15:0]));
    end

    // R7: stall with three beats in flight
    @(negedge clk);
    out_ready = 0; in_valid = 1; in_amp = pack4(111, 0, 0, 0);
    @(negedge clk);
    in_amp = pack4(222, 0, 0, 0);
    @(negedge clk);
    in_amp = pack4(333, 0, 0, 0);
    check("R7 ready low when stalled", int'(in_ready), 0);
    @(negedge clk);
    check("R7 held valid", int'(out_valid), 1);
    check("R7 held data", int'(out_amp[15:0]), 111);
    check("R7 ready stays low", int'(in_ready), 0);
    out_ready = 1;
    @(negedge clk);
    in_valid = 0;
    check("R7 second beat", int'(out_amp[15:0]), 222);
    @(negedge clk);
    check("R7 third beat", int'(out_amp[15:0]), 333);
    check("R7 third valid", int'(out_valid), 1);
    @(negedge clk);
    check("R7 drained", int'(out_valid), 0);

    // R8/R3: change channel 0 segment 0 slope to 2.0, channel 3 untouched
    wr(0, 0, 0, 0, 8192);
    beat(pack4(100, 100, 100, 2100), r);
    check("R8 rewritten ch0", int'(r[0 +: 16]), 200);
    check("R3 ch3 unaffected", int'(r[48 +: 16]), 100);
    check("R3 ch1 own table", int'(r[16 +: 16]), 200);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule